// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This unit drives the address side of a multiple-register memory transfer. A single start pulse supplies a base address, a register mask, an addressing-mode code, a load/store flag and a writeback request. The sequencer then emits one word address per cycle, each paired with the register index it belongs to. The last beat also carries the updated base value, together with a strobe that says whether the base register should take that value.

The mode code can be read in one of two ways. Read directly, it names one of four walks: incrementing after each access, incrementing before, decrementing after, or decrementing before. Read as a stack alias, it names a stack discipline, and that discipline maps to a different walk for loads than for stores. Whatever the walk, registers always come out in ascending index order, and lower indices get lower addresses. The sequencer also flags the beat in which a load targets the highest register, which is the program counter. Downstream logic uses that flag to take bit 0 of the fetched word as the instruction-set select and to clear it in the jump target.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, and until a start is accepted, `busy_o`, `valid_o` and `done_o` are low.
- R2: With `alias_i`=0, `mode_i` picks the walk directly: 0 increment-after, 1 increment-before, 2 decrement-after, 3 decrement-before. With n set mask bits, the first address is base, base+4, base-4n+4 or base-4n respectively.
- R3: Beats occupy consecutive cycles, starting the cycle after the accepting edge. Each beat's address is 4 above the previous one, and its `reg_o` is the next set mask bit in ascending order.
- R4: The number of beats (`valid_o` high) equals the number of set bits in the mask.
- R5: With `alias_i`=1 and `load_i`=1, stack code 0 (full-descending), 1 (empty-descending), 2 (full-ascending) and 3 (empty-ascending) select walks 0, 1, 2 and 3 as listed in R2.
- R6: With `alias_i`=1 and `load_i`=0, stack code 3 (empty-ascending), 2 (full-ascending), 1 (empty-descending) and 0 (full-descending) select walks 0, 1, 2 and 3 as listed in R2.
- R7: In the `done_o` cycle, `wb_val_o` equals base+4n for the two increment walks and base-4n for the two decrement walks.
- R8: `wb_en_o` is high only in the `done_o` cycle, and only when `wb_i` was high at start.
- R9: An all-zero mask gives no beats. `done_o` is high alone in the cycle after start, and `wb_val_o` equals the base.
- R10: A `start_i` pulse while busy is ignored, and so are input changes after the accepting edge. The running transfer continues unchanged.
- R11: `pc_load_o` is high exactly on the beat for register 15 of a load, and never on a store.
- R12: `last_o` is high only on the final beat, and `done_o` coincides with it. `busy_o` drops the cycle after `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Starts a transfer when the unit is idle |
| base_i | input | 32 | Base address |
| mask_i | input | 16 | Register list, bit i selects register i |
| mode_i | input | 2 | Walk code, or stack code when `alias_i` is high |
| alias_i | input | 1 | Interpret `mode_i` as a stack alias |
| load_i | input | 1 | 1 for load, 0 for store |
| wb_i | input | 1 | Request base writeback |
| busy_o | output | 1 | Transfer in progress |
| valid_o | output | 1 | Beat present on `addr_o`/`reg_o` |
| addr_o | output | 32 | Word address of this beat |
| reg_o | output | 4 | Register index of this beat |
| last_o | output | 1 | Final beat of the transfer |
| pc_load_o | output | 1 | This beat loads the program counter |
| done_o | output | 1 | Transfer complete; writeback value valid |
| wb_en_o | output | 1 | Apply `wb_val_o` to the base register |
| wb_val_o | output | 32 | Updated base value |

## Verification
The hardest situation to reach from the ports is a start request that arrives mid-transfer while every input also changes. It must leave the beats in flight untouched. The stimulus runs a full sixteen-register list and raises `start_i` on its third beat, with a different base, mask and mode. The unchanged beat stream and the unchanged writeback value are then compared against the original request. The two stack-alias tables are reached by sweeping every code for both loads and stores. Single-register lists at each end of the mask, and the empty list, cover the boundary beats.

// File: rtl/blk_xfer_pkg.sv
// Shared types for the block transfer sequencer.
// Assumes a two-bit walk code; the order of the enum values is the external encoding.
package blk_xfer_pkg;

    typedef enum logic [1:0] {
        XM_INC_AFTER  = 2'd0,
        XM_INC_BEFORE = 2'd1,
        XM_DEC_AFTER  = 2'd2,
        XM_DEC_BEFORE = 2'd3
    } xfer_mode_e;

endpackage

// File: rtl/blk_xfer_mode_map.sv
// Resolves the request code into one of four address walks.
// Assumes the stack codes are ordered full-desc, empty-desc, full-asc, empty-asc (0..3).
// For loads a stack code maps to the walk with the same number; for stores it maps to 3-code.
module blk_xfer_mode_map
    import blk_xfer_pkg::*;
(
    input  logic [1:0]  code_i,
    input  logic        alias_i,
    input  logic        load_i,
    output xfer_mode_e  mode_o
);

    // Select direct, load-alias or store-alias interpretation.
    always_comb begin
        if (alias_i && !load_i) begin
            mode_o = xfer_mode_e'(~code_i);
        end else begin
            mode_o = xfer_mode_e'(code_i);
        end
    end

endmodule

// File: rtl/blk_xfer_addr_plan.sv
// Computes the first beat address and the writeback base for a request.
// Assumes words of STEP bytes and modular address arithmetic.
module blk_xfer_addr_plan
    import blk_xfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NREG   = 16,
    parameter int STEP   = 4
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [NREG-1:0]   mask_i,
    input  xfer_mode_e        mode_i,
    output logic [ADDR_W-1:0] first_o,
    output logic [ADDR_W-1:0] wb_o
);

    localparam int CNT_W = $clog2(NREG + 1);

    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] step;

    // Count the registers in the list.
    always_comb begin
        cnt = '0;
        for (int i = 0; i < NREG; i++) begin
            cnt = cnt + CNT_W'(mask_i[i]);
        end
    end

    // Derive start address and final base from the walk.
    always_comb begin
        step = ADDR_W'(STEP);
        span = ADDR_W'(cnt) * step;
        case (mode_i)
            XM_INC_AFTER:  first_o = base_i;
            XM_INC_BEFORE: first_o = base_i + step;
            XM_DEC_AFTER:  first_o = base_i - span + step;
            default:       first_o = base_i - span;
        endcase
        if (mode_i == XM_INC_AFTER || mode_i == XM_INC_BEFORE) begin
            wb_o = base_i + span;
        end else begin
            wb_o = base_i - span;
        end
    end

endmodule

// File: rtl/blk_xfer_walker.sv
// Steps through the captured register list, one beat per cycle.
// Assumes take_i is only raised while idle; the highest index is the program counter.
module blk_xfer_walker #(
    parameter int ADDR_W = 32,
    parameter int NREG   = 16,
    parameter int STEP   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    take_i,
    input  logic [ADDR_W-1:0]       first_i,
    input  logic [ADDR_W-1:0]       wb_val_i,
    input  logic [NREG-1:0]         mask_i,
    input  logic                    load_i,
    input  logic                    wb_req_i,
    output logic                    busy_o,
    output logic                    valid_o,
    output logic [ADDR_W-1:0]       addr_o,
    output logic [$clog2(NREG)-1:0] reg_o,
    output logic                    last_o,
    output logic                    pc_load_o,
    output logic                    done_o,
    output logic                    wb_en_o,
    output logic [ADDR_W-1:0]       wb_val_o
);

    localparam int IDX_W = $clog2(NREG);
    localparam int PC_IX = NREG - 1;

    logic              busy_q;
    logic [NREG-1:0]   pend_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] wbv_q;
    logic              wbr_q;
    logic              ld_q;
    logic [IDX_W-1:0]  low_ix;
    logic [NREG-1:0]   pick;
    logic [NREG-1:0]   rest;

    // Locate the lowest pending register and the list left after it.
    always_comb begin
        low_ix = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                low_ix = IDX_W'(i);
            end
        end
        pick         = '0;
        pick[low_ix] = 1'b1;
        rest         = pend_q & ~pick;
    end

    // Beat and completion outputs.
    always_comb begin
        busy_o    = busy_q;
        valid_o   = busy_q && (pend_q != '0);
        addr_o    = addr_q;
        reg_o     = low_ix;
        done_o    = busy_q && (rest == '0);
        last_o    = valid_o && (rest == '0);
        pc_load_o = valid_o && ld_q && (low_ix == IDX_W'(PC_IX));
        wb_en_o   = done_o && wbr_q;
        wb_val_o  = wbv_q;
    end

    // Capture a request, then retire one register per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            pend_q <= '0;
            addr_q <= '0;
            wbv_q  <= '0;
            wbr_q  <= 1'b0;
            ld_q   <= 1'b0;
        end else if (take_i) begin
            busy_q <= 1'b1;
            pend_q <= mask_i;
            addr_q <= first_i;
            wbv_q  <= wb_val_i;
            wbr_q  <= wb_req_i;
            ld_q   <= load_i;
        end else if (busy_q) begin
            pend_q <= rest;
            addr_q <= addr_q + ADDR_W'(STEP);
            if (done_o) begin
                busy_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/blk_xfer_seq.sv
// Top of the block transfer address sequencer.
// Accepts a request only when idle; all request inputs are sampled on that edge alone.
module blk_xfer_seq
    import blk_xfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NREG   = 16,
    parameter int STEP   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [ADDR_W-1:0]       base_i,
    input  logic [NREG-1:0]         mask_i,
    input  logic [1:0]              mode_i,
    input  logic                    alias_i,
    input  logic                    load_i,
    input  logic                    wb_i,
    output logic                    busy_o,
    output logic                    valid_o,
    output logic [ADDR_W-1:0]       addr_o,
    output logic [$clog2(NREG)-1:0] reg_o,
    output logic                    last_o,
    output logic                    pc_load_o,
    output logic                    done_o,
    output logic                    wb_en_o,
    output logic [ADDR_W-1:0]       wb_val_o
);

    xfer_mode_e        walk;
    logic [ADDR_W-1:0] first_addr;
    logic [ADDR_W-1:0] final_base;
    logic              take;

    // Gate new requests while a transfer runs.
    always_comb take = start_i && !busy_o;

    blk_xfer_mode_map u_map (
        .code_i  (mode_i),
        .alias_i (alias_i),
        .load_i  (load_i),
        .mode_o  (walk)
    );

    blk_xfer_addr_plan #(.ADDR_W(ADDR_W), .NREG(NREG), .STEP(STEP)) u_plan (
        .base_i  (base_i),
        .mask_i  (mask_i),
        .mode_i  (walk),
        .first_o (first_addr),
        .wb_o    (final_base)
    );

    blk_xfer_walker #(.ADDR_W(ADDR_W), .NREG(NREG), .STEP(STEP)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_i    (take),
        .first_i   (first_addr),
        .wb_val_i  (final_base),
        .mask_i    (mask_i),
        .load_i    (load_i),
        .wb_req_i  (wb_i),
        .busy_o    (busy_o),
        .valid_o   (valid_o),
        .addr_o    (addr_o),
        .reg_o     (reg_o),
        .last_o    (last_o),
        .pc_load_o (pc_load_o),
        .done_o    (done_o),
        .wb_en_o   (wb_en_o),
        .wb_val_o  (wb_val_o)
    );

endmodule

// File: rtl/blk_xfer_seq_chk.sv
// Protocol checker for the block transfer sequencer, attached by bind.
// Observes only the top-level ports.
module blk_xfer_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int NREG   = 16,
    parameter int STEP   = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start_i,
    input logic                    busy_o,
    input logic                    valid_o,
    input logic [ADDR_W-1:0]       addr_o,
    input logic [$clog2(NREG)-1:0] reg_o,
    input logic                    last_o,
    input logic                    pc_load_o,
    input logic                    done_o,
    input logic                    wb_en_o
);

    // R1
    idle_after_reset_chk: assert property (@(posedge clk)
        !rst_n |=> !busy_o && !valid_o && !done_o);

    // R3
    beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !last_o |=> valid_o && addr_o == $past(addr_o) + ADDR_W'(STEP)
                               && reg_o > $past(reg_o));

    // R12
    last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> done_o && valid_o);

    // R12
    drop_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    // R8
    wb_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> done_o);

    // R11
    pc_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |-> valid_o && reg_o == '1);

    // R10
    hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !done_o && start_i |=> busy_o);

endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(.ADDR_W(ADDR_W), .NREG(NREG), .STEP(STEP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .valid_o   (valid_o),
    .addr_o    (addr_o),
    .reg_o     (reg_o),
    .last_o    (last_o),
    .pc_load_o (pc_load_o),
    .done_o    (done_o),
    .wb_en_o   (wb_en_o)
);

// File: tb/test_blk_xfer_seq.sv
module test_blk_xfer_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] base_i = '0;
    logic [15:0] mask_i = '0;
    logic [1:0]  mode_i = '0;
    logic        alias_i = 1'b0;
    logic        load_i = 1'b0;
    logic        wb_i = 1'b0;
    logic        busy_o, valid_o, last_o, pc_load_o, done_o, wb_en_o;
    logic [31:0] addr_o, wb_val_o;
    logic [3:0]  reg_o;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    blk_xfer_seq i_blk_xfer_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
        .mask_i(mask_i), .mode_i(mode_i), .alias_i(alias_i), .load_i(load_i),
        .wb_i(wb_i), .busy_o(busy_o), .valid_o(valid_o), .addr_o(addr_o),
        .reg_o(reg_o), .last_o(last_o), .pc_load_o(pc_load_o), .done_o(done_o),
        .wb_en_o(wb_en_o), .wb_val_o(wb_val_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One transfer against a behavioural model; poke raises start mid-run.
    task automatic run_xfer(input logic [31:0] base, input logic [15:0] mask,
                            input logic [1:0] code, input logic as_alias,
                            input logic ld, input logic wb, input bit poke);
        int walk;
        int n;
        int a_regs[$];
        logic [31:0] first, wbv, a;
        string rq;
        rq = as_alias ? (ld ? "R5" : "R6") : "R2";
        if (!as_alias) walk = code;
        else if (ld) begin
            case (code)
                2'd0: walk = 0; 2'd1: walk = 1; 2'd2: walk = 2; default: walk = 3;
            endcase
        end else begin
            case (code)
                2'd3: walk = 0; 2'd2: walk = 1; 2'd1: walk = 2; default: walk = 3;
            endcase
        end
        n = 0;
        for (int i = 0; i < 16; i++) if (mask[i]) begin a_regs.push_back(i); n++; end
        case (walk)
            0: first = base;
            1: first = base + 32'd4;
            2: first = base - 32'(4 * n) + 32'd4;
            default: first = base - 32'(4 * n);
        endcase
        wbv = (walk < 2) ? base + 32'(4 * n) : base - 32'(4 * n);

        @(negedge clk);
        base_i = base; mask_i = mask; mode_i = code; alias_i = as_alias;
        load_i = ld; wb_i = wb; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        base_i = ~base; mask_i = ~mask; mode_i = ~code; wb_i = ~wb; load_i = ~ld;
        if (n == 0) begin
            chk(valid_o == 1'b0, "R9", "no beat", 32'(valid_o), 32'd0);
            chk(done_o == 1'b1, "R9", "done", 32'(done_o), 32'd1);
            chk(wb_val_o == base, "R9", "base kept", wb_val_o, base);
            chk(wb_en_o == wb, "R8", "wb_en", 32'(wb_en_o), 32'(wb));
        end else begin
            a = first;
            for (int k = 0; k < n; k++) begin
                if (poke && k == 3) start_i = 1'b0;
                chk(valid_o == 1'b1, "R4", "beat valid", 32'(valid_o), 32'd1);
                chk(addr_o == a, (k == 0) ? rq : "R3", "addr", addr_o, a);
                chk(reg_o == 4'(a_regs[k]), "R3", "reg", 32'(reg_o), 32'(a_regs[k]));
                chk(last_o == (k == n - 1), "R12", "last", 32'(last_o), 32'(k == n - 1));
                chk(done_o == (k == n - 1), "R12", "done", 32'(done_o), 32'(k == n - 1));
                chk(pc_load_o == (ld && a_regs[k] == 15), "R11", "pc beat",
                    32'(pc_load_o), 32'(ld && a_regs[k] == 15));
                if (k == n - 1) begin
                    chk(wb_val_o == wbv, "R7", "wb value", wb_val_o, wbv);
                    chk(wb_en_o == wb, "R8", "wb_en", 32'(wb_en_o), 32'(wb));
                end else begin
                    chk(wb_en_o == 1'b0, "R8", "wb_en early", 32'(wb_en_o), 32'd0);
                end
                if (poke && k == 2) begin
                    start_i = 1'b1; base_i = 32'h1234_5670; mask_i = 16'h0001;
                end
                a = a + 32'd4;
                @(negedge clk);
            end
            if (poke) chk(1'b1, "R10", "ignored start", 32'd0, 32'd0);
        end
        if (n == 0) @(negedge clk);
        chk(busy_o == 1'b0, "R12", "busy drop", 32'(busy_o), 32'd0);
        chk(valid_o == 1'b0, "R4", "no extra beat", 32'(valid_o), 32'd0);
    endtask

    initial begin
        #400000;
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] masks [6];
        masks = '{16'h0001, 16'h8000, 16'hFFFF, 16'h00A5, 16'h0000, 16'h8421};
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0 && valid_o == 1'b0 && done_o == 1'b0, "R1", "idle",
            {29'd0, busy_o, valid_o, done_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b0 && valid_o == 1'b0 && done_o == 1'b0, "R1", "idle after",
            {29'd0, busy_o, valid_o, done_o}, 32'd0);
        for (int c = 0; c < 4; c++)
            for (int al = 0; al < 2; al++)
                for (int ld = 0; ld < 2; ld++)
                    for (int m = 0; m < 6; m++)
                        run_xfer(32'h0000_1000 + 32'(m * 256) - 32'(c * 8), masks[m],
                                 2'(c), 1'(al), 1'(ld), 1'(m % 2), 1'b0);
        // low base wraps on decrement
        run_xfer(32'h0000_0010, 16'hFFFF, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0);
        // R10: start raised mid-transfer with new inputs
        run_xfer(32'h0000_8000, 16'hFFFF, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1);
        run_xfer(32'h0000_8000, 16'hFFFF, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule